// File: doc/BRIEF.md
# Reset and Wake-up Start-up Delay Timer

This block keeps the core clock gated after a chip reset or a wake from sleep, and opens it only when a start-up interval has run out. The interval has two parts that run one after the other. The first is a fixed count of clock cycles. The second, used only after a reset, is a timed wait. That wait counts pulses on a slow tick input, and its length comes from a two-bit start-up select code. A wake from sleep always takes the short cycle-only path. A reset takes a longer cycle count and then, when the code calls for it, either a short or a long tick wait.

The select code and the brown-out enable are sampled once, on the clock edge that accepts a request. Code 00 skips the timed wait only while brown-out detection is enabled. Without that protection it falls back to the short wait. Code 11 is reserved and behaves like the longest setting, so that the gate never opens early. When the gate opens, `clk_en` goes high and stays high, and `ready` pulses for one cycle. Any new request drops `clk_en` and starts the count again from zero with the new profile.

Top module: `startup_gate_timer`

## Requirements
- R1: While `rst_n` is low, `clk_en` and `ready` are 0. The first rising edge after `rst_n` goes high is treated as a reset request that samples `sut_sel` and `bod_en`.
- R2: When `wake_req` is sampled high (and `rst_evt` is low), `clk_en` rises on the WAKE_CYC-th (default 6) later edge, for every `sut_sel` and `bod_en` value, and `ms_tick` has no effect.
- R3: After a reset request with `sut_sel`=2'b00 and `bod_en`=1, `clk_en` rises on the RST_CYC-th (default 14) edge after the request edge, with no tick wait.
- R4: After a reset request with `sut_sel`=2'b01, or with 2'b00 and `bod_en`=0, `clk_en` rises after RST_CYC cycles plus SHORT_TICKS counted ticks.
- R5: After a reset request with `sut_sel`=2'b10 or the reserved 2'b11, `clk_en` rises after RST_CYC cycles plus LONG_TICKS counted ticks.
- R6: The tick wait starts only after the cycle count ends. A tick is counted only on edges after the edge that completes the cycle count, and `clk_en` rises on the edge that samples the last needed tick.
- R7: `ready` is high for exactly the one cycle in which `clk_en` first reads 1 after going high.
- R8: A request during a count restarts it from zero with the profile of the new request. If `rst_evt` and `wake_req` are high in the same cycle, the reset profile is used.
- R9: A request sampled on the same edge that would complete the interval wins. `clk_en` stays 0, no `ready` pulse is produced, and a fresh interval begins.
- R10: Once high, `clk_en` stays high until the next request, whatever `sut_sel`, `bod_en` and `ms_tick` do.
- R11: Changes to `sut_sel` or `bod_en` after the request edge do not alter the interval already in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset, counts as a reset request on release |
| rst_evt | input | 1 | One-cycle reset-source request |
| wake_req | input | 1 | One-cycle wake-from-sleep request |
| sut_sel | input | 2 | Start-up select code |
| bod_en | input | 1 | Brown-out detection is enabled |
| ms_tick | input | 1 | Slow timebase pulse, one cycle wide |
| clk_en | output | 1 | Core clock enable and reset release, level |
| ready | output | 1 | One-cycle pulse when the gate opens |

## Verification
The two functions that can meet in one cycle are the completion of an interval, which raises `clk_en` and `ready`, and the acceptance of a new request, which must clear them. A directed case sends a second wake request on exactly the edge that ends a wake interval. It expects both outputs low after that edge and a full new interval to follow. The constrained-random phase sends reset and wake requests at rates close to the interval length, so they often land on completion edges and in the middle of tick waits. Each cycle the outputs are compared with a bench model built from the requirements.

// File: rtl/sdt_pkg.sv
package sdt_pkg;

  typedef enum logic [1:0] {
    SDT_ARM  = 2'd0,
    SDT_CYC  = 2'd1,
    SDT_TICK = 2'd2,
    SDT_RUN  = 2'd3
  } sdt_state_e;

  typedef enum logic [1:0] {
    SUT_BOD_ONLY = 2'b00,
    SUT_FAST     = 2'b01,
    SUT_SLOW     = 2'b10,
    SUT_RESERVED = 2'b11
  } sut_code_e;

endpackage

// File: rtl/sdt_profile_dec.sv
module sdt_profile_dec
  import sdt_pkg::*;
#(
  parameter int WAKE_CYC    = 6,
  parameter int RST_CYC     = 14,
  parameter int SHORT_TICKS = 41,
  parameter int LONG_TICKS  = 650,
  parameter int CW          = 4,
  parameter int TW          = 10
) (
  input  logic          from_rst,
  input  logic [1:0]    sel,
  input  logic          bod_on,
  output logic [CW-1:0] cyc_tgt,
  output logic [TW-1:0] tick_tgt,
  output logic          use_ticks
);

  sut_code_e code;
  assign code = sut_code_e'(sel);

  always_comb begin
    cyc_tgt  = from_rst ? CW'(RST_CYC) : CW'(WAKE_CYC);
    tick_tgt = '0;
    if (from_rst) begin
      case (code)
        SUT_BOD_ONLY: tick_tgt = bod_on ? '0 : TW'(SHORT_TICKS);
        SUT_FAST:     tick_tgt = TW'(SHORT_TICKS);
        default:      tick_tgt = TW'(LONG_TICKS);
      endcase
    end
  end

  assign use_ticks = |tick_tgt;

endmodule

// File: rtl/sdt_cycle_cnt.sv
module sdt_cycle_cnt #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          run,
  input  logic [CW-1:0] tgt,
  output logic          last
);

  logic [CW-1:0] cnt_q, cnt_d;

  assign last = run && (cnt_q == tgt - CW'(1));

  always_comb begin
    cnt_d = cnt_q;
    if (clr)       cnt_d = '0;
    else if (last) cnt_d = '0;
    else if (run)  cnt_d = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  AST_CYC_BELOW_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt_q < tgt)); // R2

endmodule

// File: rtl/sdt_tick_cnt.sv
module sdt_tick_cnt #(
  parameter int TW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          run,
  input  logic          tick,
  input  logic [TW-1:0] tgt,
  output logic          last
);

  logic [TW-1:0] cnt_q, cnt_d;
  logic          step;

  assign step = run && tick;
  assign last = step && (cnt_q == tgt - TW'(1));

  always_comb begin
    cnt_d = cnt_q;
    if (clr)       cnt_d = '0;
    else if (last) cnt_d = '0;
    else if (step) cnt_d = cnt_q + TW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  AST_TICK_HOLD_NO_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !clr) |=> $stable(cnt_q)); // R6

  AST_TICK_IDLE_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !clr) |=> $stable(cnt_q)); // R6

endmodule

// File: rtl/startup_gate_timer.sv
module startup_gate_timer
  import sdt_pkg::*;
#(
  parameter int WAKE_CYC    = 6,
  parameter int RST_CYC     = 14,
  parameter int SHORT_TICKS = 41,
  parameter int LONG_TICKS  = 650
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rst_evt,
  input  logic       wake_req,
  input  logic [1:0] sut_sel,
  input  logic       bod_en,
  input  logic       ms_tick,
  output logic       clk_en,
  output logic       ready
);

  localparam int CYC_MAX  = (WAKE_CYC > RST_CYC) ? WAKE_CYC : RST_CYC;
  localparam int TICK_MAX = (SHORT_TICKS > LONG_TICKS) ? SHORT_TICKS : LONG_TICKS;
  localparam int CW       = $clog2(CYC_MAX + 1);
  localparam int TW       = $clog2(TICK_MAX + 1);

  sdt_state_e    state_q, state_d;
  logic [CW-1:0] cyc_tgt_q, cyc_tgt_d, cyc_tgt_new;
  logic [TW-1:0] tick_tgt_q, tick_tgt_d, tick_tgt_new;
  logic          ticks_q, ticks_d, ticks_new;
  logic          clk_en_q, clk_en_d;
  logic          ready_q, ready_d;
  logic          from_rst, req, go_run;
  logic          cyc_run, cyc_last, tick_run, tick_last;

  assign from_rst = (state_q == SDT_ARM) || rst_evt;
  assign req      = from_rst || wake_req;
  assign cyc_run  = (state_q == SDT_CYC)  && !req;
  assign tick_run = (state_q == SDT_TICK) && !req;

  sdt_profile_dec #(
    .WAKE_CYC    (WAKE_CYC),
    .RST_CYC     (RST_CYC),
    .SHORT_TICKS (SHORT_TICKS),
    .LONG_TICKS  (LONG_TICKS),
    .CW          (CW),
    .TW          (TW)
  ) u_dec (
    .from_rst  (from_rst),
    .sel       (sut_sel),
    .bod_on    (bod_en),
    .cyc_tgt   (cyc_tgt_new),
    .tick_tgt  (tick_tgt_new),
    .use_ticks (ticks_new)
  );

  sdt_cycle_cnt #(.CW(CW)) u_cyc (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (req),
    .run   (cyc_run),
    .tgt   (cyc_tgt_q),
    .last  (cyc_last)
  );

  sdt_tick_cnt #(.TW(TW)) u_tick (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (req),
    .run   (tick_run),
    .tick  (ms_tick),
    .tgt   (tick_tgt_q),
    .last  (tick_last)
  );

  always_comb begin
    state_d    = state_q;
    cyc_tgt_d  = cyc_tgt_q;
    tick_tgt_d = tick_tgt_q;
    ticks_d    = ticks_q;
    go_run     = 1'b0;
    if (req) begin
      state_d    = SDT_CYC;
      cyc_tgt_d  = cyc_tgt_new;
      tick_tgt_d = tick_tgt_new;
      ticks_d    = ticks_new;
    end else begin
      case (state_q)
        SDT_CYC: begin
          if (cyc_last) begin
            state_d = ticks_q ? SDT_TICK : SDT_RUN;
            go_run  = !ticks_q;
          end
        end
        SDT_TICK: begin
          if (tick_last) begin
            state_d = SDT_RUN;
            go_run  = 1'b1;
          end
        end
        default: ;
      endcase
    end
    clk_en_d = req ? 1'b0 : (go_run ? 1'b1 : clk_en_q);
    ready_d  = go_run;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= SDT_ARM;
      cyc_tgt_q  <= '0;
      tick_tgt_q <= '0;
      ticks_q    <= 1'b0;
      clk_en_q   <= 1'b0;
      ready_q    <= 1'b0;
    end else begin
      state_q    <= state_d;
      cyc_tgt_q  <= cyc_tgt_d;
      tick_tgt_q <= tick_tgt_d;
      ticks_q    <= ticks_d;
      clk_en_q   <= clk_en_d;
      ready_q    <= ready_d;
    end
  end

  assign clk_en = clk_en_q;
  assign ready  = ready_q;

  AST_READY_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    ready |=> !ready); // R7

  AST_READY_ON_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> (clk_en && !$past(clk_en))); // R7

  AST_REQUEST_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_evt || wake_req) |=> (!clk_en && !ready)); // R9

  AST_OPEN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en && !rst_evt && !wake_req) |=> clk_en); // R10

  AST_GATED_WHILE_COUNTING: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SDT_CYC || state_q == SDT_TICK) |-> !clk_en); // R6

endmodule

// File: tb/tb_startup_gate_timer.sv
module tb_startup_gate_timer;

  localparam int WC = 6;
  localparam int RC = 14;
  localparam int ST = 3;
  localparam int LT = 5;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rst_evt = 1'b0;
  logic       wake_req = 1'b0;
  logic [1:0] sut_sel = 2'b00;
  logic       bod_en = 1'b1;
  logic       ms_tick = 1'b0;
  logic       clk_en, ready;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;
  bit rand_on = 1'b0;

  always #10 clk = ~clk;

  startup_gate_timer #(
    .WAKE_CYC(WC), .RST_CYC(RC), .SHORT_TICKS(ST), .LONG_TICKS(LT)
  ) dut (
    .clk(clk), .rst_n(rst_n), .rst_evt(rst_evt), .wake_req(wake_req),
    .sut_sel(sut_sel), .bod_en(bod_en), .ms_tick(ms_tick),
    .clk_en(clk_en), .ready(ready)
  );

  // Reference model derived from the requirements
  int m_phase;   // 0 arm, 1 cycles, 2 ticks, 3 open
  int m_cnt, m_ncyc, m_ntick;
  bit m_en, m_rdy;

  function automatic int ticks_for(input bit is_rst, input logic [1:0] s, input bit b);
    if (!is_rst) return 0;
    if (s == 2'b00) return b ? 0 : ST;
    if (s == 2'b01) return ST;
    return LT;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_phase = 0; m_cnt = 0; m_ncyc = 0; m_ntick = 0; m_en = 0; m_rdy = 0;
    end else begin
      bit isr;
      isr = (m_phase == 0) || rst_evt;
      m_rdy = 0;
      if (isr || wake_req) begin
        m_phase = 1; m_cnt = 0; m_en = 0;
        m_ncyc  = isr ? RC : WC;
        m_ntick = ticks_for(isr, sut_sel, bod_en);
      end else if (m_phase == 1) begin
        m_cnt++;
        if (m_cnt == m_ncyc) begin
          m_cnt = 0;
          if (m_ntick == 0) begin m_phase = 3; m_en = 1; m_rdy = 1; end
          else m_phase = 2;
        end
      end else if (m_phase == 2 && ms_tick) begin
        m_cnt++;
        if (m_cnt == m_ntick) begin m_phase = 3; m_en = 1; m_rdy = 1; end
      end
    end
  end

  task automatic chk(input bit got, input bit exp, input string tag);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic step(input bit r, input bit w, input bit t);
    rst_evt = r; wake_req = w; ms_tick = t;
    @(posedge clk);
    #2;
  endtask

  // after the request edge: n edges until open, tick input held at t
  task automatic expect_open(input int n, input bit t, input string tag);
    for (int i = 1; i < n; i++) begin
      step(0, 0, t);
      chk(clk_en, 1'b0, tag);
    end
    step(0, 0, t);
    chk(clk_en, 1'b1, tag);
    chk(ready, 1'b1, {tag, " R7"});
    step(0, 0, 0);
    chk(ready, 1'b0, "R7 pulse width");
    chk(clk_en, 1'b1, "R10 stays open");
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    // R1 reset state
    repeat (3) @(posedge clk);
    #2;
    chk(clk_en, 1'b0, "R1 clk_en in reset");
    chk(ready, 1'b0, "R1 ready in reset");
    sut_sel = 2'b00; bod_en = 1'b1;
    rst_n = 1'b1;
    step(0, 0, 1);               // first edge acts as reset request
    expect_open(RC, 1, "R1 R3 release after reset");

    // R2 wake ignores code and ticks
    sut_sel = 2'b10; bod_en = 1'b0;
    step(0, 1, 1);
    expect_open(WC, 1, "R2 wake sel=10");
    sut_sel = 2'b11;
    step(0, 1, 0);
    expect_open(WC, 0, "R2 wake sel=11");

    // R10 open state unaffected by inputs
    for (int i = 0; i < 10; i++) begin
      sut_sel = 2'($urandom); bod_en = 1'($urandom);
      step(0, 0, 1'($urandom));
      chk(clk_en, 1'b1, "R10 hold open");
      chk(ready, 1'b0, "R10 no extra ready");
    end

    // R3 code 00 with brown-out on
    sut_sel = 2'b00; bod_en = 1'b1;
    step(1, 0, 1);
    expect_open(RC, 1, "R3 code 00");

    // R4 code 01, and 00 without brown-out
    sut_sel = 2'b01; bod_en = 1'b1;
    step(1, 0, 1);
    expect_open(RC + ST, 1, "R4 code 01");
    sut_sel = 2'b00; bod_en = 1'b0;
    step(1, 0, 1);
    expect_open(RC + ST, 1, "R4 code 00 no bod");

    // R5 codes 10 and 11
    sut_sel = 2'b10; bod_en = 1'b1;
    step(1, 0, 1);
    expect_open(RC + LT, 1, "R5 code 10");
    sut_sel = 2'b11;
    step(1, 0, 1);
    expect_open(RC + LT, 1, "R5 code 11");

    // R11 inputs changed after the request edge
    sut_sel = 2'b00; bod_en = 1'b1;
    step(1, 0, 1);
    sut_sel = 2'b10; bod_en = 1'b0;
    expect_open(RC, 1, "R11 latched code");

    // R6 ticks during the cycle phase are not counted
    sut_sel = 2'b01; bod_en = 1'b1;
    step(1, 0, 0);
    for (int i = 1; i < RC; i++) begin
      step(0, 0, (i % 5) == 0);
      chk(clk_en, 1'b0, "R6 cycle phase");
    end
    step(0, 0, 1);               // completes cycle count, tick ignored
    chk(clk_en, 1'b0, "R6 boundary tick ignored");
    for (int k = 1; k <= ST; k++) begin
      step(0, 0, 0);
      step(0, 0, 0);
      chk(clk_en, 1'b0, "R6 waiting for tick");
      step(0, 0, 1);
      chk(clk_en, k == ST, "R6 open on last tick");
    end
    chk(ready, 1'b1, "R6 R7 ready on last tick");

    // R8 restart with new profile, and reset wins over wake
    step(0, 1, 0);
    step(0, 0, 0);
    step(0, 0, 0);
    sut_sel = 2'b00; bod_en = 1'b1;
    step(1, 0, 0);
    expect_open(RC, 0, "R8 reset restarts wake");
    step(1, 1, 0);
    expect_open(RC, 0, "R8 reset beats wake");

    // R9 request on the completion edge
    step(0, 1, 0);
    for (int i = 1; i < WC; i++) step(0, 0, 0);
    step(0, 1, 0);
    chk(clk_en, 1'b0, "R9 clk_en on collision");
    chk(ready, 1'b0, "R9 ready on collision");
    expect_open(WC, 0, "R9 fresh interval");

    // constrained random against the model
    rand_on = 1'b1;
    for (int i = 0; i < 30000; i++) begin
      bit r, w;
      r = ($urandom % 60) == 0;
      w = ($urandom % 40) == 0;
      sut_sel = 2'($urandom);
      bod_en  = 1'($urandom);
      step(r, w, ($urandom % 3) == 0);
      chk(clk_en, m_en, "R8 R9 random clk_en");
      chk(ready, m_rdy, "R7 R9 random ready");
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule